// File: doc/BRIEF.md
# Segmentable Serial Readout Deserializer

The block gathers serial pixel data from either one readout chip or four chips read side by side, and turns it into 32-bit parallel words for a host processor that runs on a slower clock. A fast capture clock shifts the serial bits into one 32-bit shift register. In single mode one serial line fills the whole register. In quad mode the register works as four 8-bit lanes, and each lane is fed from its own serial line at the same time.

When a word is complete it is copied into a holding latch in one capture cycle. A toggle handshake then carries a "word ready" event into the host clock domain. The host sees a valid flag, reads the parallel word and acknowledges it, and this frees the latch for the next word. If a word completes while the latch still holds an unread word, the new word is dropped and a sticky overrun flag is set on the host side. A capture enable gates the shifting, and the lane mode is sampled only while capture is disabled.

Top module: `dsr_readout`

## Requirements
- R1: After reset, rd_valid_o is 0, ovr_o is 0 and rd_data_o is 0.
- R2: With quad_i=0, each enabled capture edge shifts ser_i[0] into bit 0 of the register. A word is complete after 32 shifts, and the first bit received ends up at bit 31.
- R3: With quad_i=1, lane k (k=0..3) shifts ser_i[k] into bits [8k+7:8k]. A word is complete after 8 shifts, and the first bit of each lane ends up at bit 8k+7.
- R4: A completed word is offered on the host side: rd_valid_o rises and rd_data_o equals the completed word.
- R5: While rd_valid_o is 1 and rd_ack_i is 0, rd_valid_o stays 1 and rd_data_o does not change.
- R6: rd_ack_i=1 while rd_valid_o=1 drops rd_valid_o at the next host edge. A later word is then delivered normally.
- R7: If a word completes while the latched word is still unacknowledged, the new word is discarded and never offered, and ovr_o becomes 1 and stays 1.
- R8: ovr_clr_i=1 at a host edge clears ovr_o.
- R9: Dropping cap_en_i resets the bit count. A partial word is discarded and never offered.
- R10: quad_i is sampled only while cap_en_i is 0. A change of quad_i while capture is enabled has no effect on the word being assembled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cap_clk_i | input | 1 | Fast capture clock |
| host_clk_i | input | 1 | Slow host read clock |
| rst_ni | input | 1 | Asynchronous active-low reset, both domains |
| cap_en_i | input | 1 | Capture enable (capture domain) |
| quad_i | input | 1 | 0: one 32-bit lane, 1: four 8-bit lanes |
| ser_i | input | 4 | Serial inputs; bit k feeds lane k, bit 0 feeds single mode |
| rd_data_o | output | 32 | Latched parallel word |
| rd_valid_o | output | 1 | Word available to the host (host domain) |
| rd_ack_i | input | 1 | Host acknowledge of the current word |
| ovr_o | output | 1 | Sticky overrun flag (host domain) |
| ovr_clr_i | input | 1 | Clears the overrun flag (host domain) |

## Verification
The assertions assume three things about the inputs: quad_i changes only while capture is disabled, or else its change is simply not sampled; rd_ack_i and ovr_clr_i are synchronous to host_clk_i; and the capture clock runs several times faster than the host clock, so that an acknowledge reaches the capture side before the next host edge. The stimulus drives the serial lines and the enable on falling capture edges, and drives the acknowledge and clear as one-cycle pulses on falling host edges. It switches the mode in the middle of a word only in the test that checks that such a change is ignored.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
  typedef enum logic {
    MODE_SINGLE = 1'b0,
    MODE_QUAD   = 1'b1
  } lane_mode_e;
endpackage

// File: rtl/dsr_sync.sv
module dsr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= {q[STAGES-2:0], d_i};
  end

  assign q_o = q[STAGES-1];
endmodule

// File: rtl/dsr_shifter.sv
module dsr_shifter
  import dsr_pkg::*;
#(
  parameter int W     = 32,
  parameter int LANES = 4,
  localparam int SEG  = W / LANES,
  localparam int CW   = $clog2(W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             quad_i,
  input  logic [LANES-1:0] ser_i,
  output lane_mode_e       mode_o,
  output logic [CW-1:0]    cnt_o,
  output logic [W-1:0]     word_o,
  output logic             done_o
);
  localparam logic [CW-1:0] LAST_S = CW'(W - 1);
  localparam logic [CW-1:0] LAST_Q = CW'(SEG - 1);

  lane_mode_e    mode_q;
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  sr_q;
  logic [W-1:0]  single_nxt;
  logic [W-1:0]  quad_nxt;
  logic [W-1:0]  sr_nxt;
  logic [CW-1:0] last;

  assign single_nxt = {sr_q[W-2:0], ser_i[0]};

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign quad_nxt[k*SEG +: SEG] = {sr_q[k*SEG +: SEG-1], ser_i[k]};
  end

  assign sr_nxt = (mode_q == MODE_QUAD) ? quad_nxt : single_nxt;
  assign last   = (mode_q == MODE_QUAD) ? LAST_Q : LAST_S;
  assign done_o = en_i && (cnt_q == last);
  assign word_o = sr_nxt;
  assign mode_o = mode_q;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_SINGLE;
      cnt_q  <= '0;
      sr_q   <= '0;
    end else if (!en_i) begin
      // mode is only taken while idle; partial words are discarded
      mode_q <= lane_mode_e'(quad_i);
      cnt_q  <= '0;
    end else begin
      sr_q  <= sr_nxt;
      cnt_q <= done_o ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/dsr_xfer.sv
module dsr_xfer #(
  parameter int W = 32
) (
  input  logic         cap_clk_i,
  input  logic         host_clk_i,
  input  logic         rst_ni,
  input  logic         done_i,
  input  logic [W-1:0] word_i,
  input  logic         rd_ack_i,
  input  logic         ovr_clr_i,
  output logic [W-1:0] rd_data_o,
  output logic         rd_valid_o,
  output logic         ovr_o,
  output logic         held_o
);
  // capture domain
  logic [W-1:0] latch_q;
  logic         held_q;
  logic         req_tgl_q;
  logic         ovr_tgl_q;
  logic         ack_sync;
  logic         ack_seen_q;
  logic         ack_edge;

  // host domain
  logic         req_sync;
  logic         req_seen_q;
  logic         valid_q;
  logic         ack_tgl_q;
  logic         ovr_sync;
  logic         ovr_seen_q;
  logic         ovr_q;

  dsr_sync u_ack_sync (.clk_i(cap_clk_i),  .rst_ni(rst_ni), .d_i(ack_tgl_q), .q_o(ack_sync));
  dsr_sync u_req_sync (.clk_i(host_clk_i), .rst_ni(rst_ni), .d_i(req_tgl_q), .q_o(req_sync));
  dsr_sync u_ovr_sync (.clk_i(host_clk_i), .rst_ni(rst_ni), .d_i(ovr_tgl_q), .q_o(ovr_sync));

  assign ack_edge = ack_sync ^ ack_seen_q;

  always_ff @(posedge cap_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q    <= '0;
      held_q     <= 1'b0;
      req_tgl_q  <= 1'b0;
      ovr_tgl_q  <= 1'b0;
      ack_seen_q <= 1'b0;
    end else begin
      ack_seen_q <= ack_sync;
      if (done_i && !held_q) begin
        latch_q   <= word_i;
        held_q    <= 1'b1;
        req_tgl_q <= ~req_tgl_q;
      end else begin
        if (done_i) ovr_tgl_q <= ~ovr_tgl_q;
        if (ack_edge) held_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge host_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_seen_q <= 1'b0;
      valid_q    <= 1'b0;
      ack_tgl_q  <= 1'b0;
      ovr_seen_q <= 1'b0;
      ovr_q      <= 1'b0;
    end else begin
      req_seen_q <= req_sync;
      ovr_seen_q <= ovr_sync;
      if (req_sync ^ req_seen_q) begin
        valid_q <= 1'b1;
      end else if (valid_q && rd_ack_i) begin
        valid_q   <= 1'b0;
        ack_tgl_q <= ~ack_tgl_q;
      end
      if (ovr_sync ^ ovr_seen_q) ovr_q <= 1'b1;
      else if (ovr_clr_i)        ovr_q <= 1'b0;
    end
  end

  assign rd_data_o  = latch_q;
  assign rd_valid_o = valid_q;
  assign ovr_o      = ovr_q;
  assign held_o     = held_q;
endmodule

// File: rtl/dsr_readout.sv
module dsr_readout
  import dsr_pkg::*;
#(
  parameter int W     = 32,
  parameter int LANES = 4,
  localparam int CW   = $clog2(W)
) (
  input  logic             cap_clk_i,
  input  logic             host_clk_i,
  input  logic             rst_ni,
  input  logic             cap_en_i,
  input  logic             quad_i,
  input  logic [LANES-1:0] ser_i,
  output logic [W-1:0]     rd_data_o,
  output logic             rd_valid_o,
  input  logic             rd_ack_i,
  output logic             ovr_o,
  input  logic             ovr_clr_i
);
  lane_mode_e    mode;
  logic [CW-1:0] cnt;
  logic [W-1:0]  word;
  logic          done;
  logic          held;

  dsr_shifter #(.W(W), .LANES(LANES)) u_shift (
    .clk_i  (cap_clk_i),
    .rst_ni (rst_ni),
    .en_i   (cap_en_i),
    .quad_i (quad_i),
    .ser_i  (ser_i),
    .mode_o (mode),
    .cnt_o  (cnt),
    .word_o (word),
    .done_o (done)
  );

  dsr_xfer #(.W(W)) u_xfer (
    .cap_clk_i  (cap_clk_i),
    .host_clk_i (host_clk_i),
    .rst_ni     (rst_ni),
    .done_i     (done),
    .word_i     (word),
    .rd_ack_i   (rd_ack_i),
    .ovr_clr_i  (ovr_clr_i),
    .rd_data_o  (rd_data_o),
    .rd_valid_o (rd_valid_o),
    .ovr_o      (ovr_o),
    .held_o     (held)
  );
endmodule

// File: rtl/dsr_readout_chk.sv
module dsr_readout_chk #(
  parameter int W     = 32,
  parameter int LANES = 4,
  localparam int SEG  = W / LANES,
  localparam int CW   = $clog2(W)
) (
  input logic          cap_clk_i,
  input logic          host_clk_i,
  input logic          rst_ni,
  input logic          cap_en_i,
  input logic          mode_i,
  input logic [CW-1:0] cnt_i,
  input logic          held_i,
  input logic [W-1:0]  rd_data_i,
  input logic          rd_valid_i,
  input logic          rd_ack_i,
  input logic          ovr_i,
  input logic          ovr_clr_i
);
  // R3: a quad-mode count never passes the lane width
  p_cnt_bound_r3: assert property (@(posedge cap_clk_i) disable iff (!rst_ni)
    mode_i |-> (cnt_i < CW'(SEG)));

  // R5: an unacknowledged latched word is never overwritten
  p_latch_hold_r5: assert property (@(posedge cap_clk_i) disable iff (!rst_ni)
    held_i |=> $stable(rd_data_i));

  // R5: host view is stable until acknowledged
  p_data_stable_r5: assert property (@(posedge host_clk_i) disable iff (!rst_ni)
    (rd_valid_i && !rd_ack_i) |=> (rd_valid_i && $stable(rd_data_i)));

  // R6: acknowledge drops valid
  p_ack_drop_r6: assert property (@(posedge host_clk_i) disable iff (!rst_ni)
    (rd_valid_i && rd_ack_i) |=> !rd_valid_i);

  // R7: overrun flag is sticky
  p_ovr_sticky_r7: assert property (@(posedge host_clk_i) disable iff (!rst_ni)
    (ovr_i && !ovr_clr_i) |=> ovr_i);

  // R9: disabled capture holds the count at zero
  p_disable_clr_r9: assert property (@(posedge cap_clk_i) disable iff (!rst_ni)
    !cap_en_i |=> (cnt_i == '0));

  // R10: mode frozen while capture enabled
  p_mode_frozen_r10: assert property (@(posedge cap_clk_i) disable iff (!rst_ni)
    cap_en_i |=> $stable(mode_i));
endmodule

bind dsr_readout dsr_readout_chk #(.W(W), .LANES(LANES)) u_chk (
  .cap_clk_i  (cap_clk_i),
  .host_clk_i (host_clk_i),
  .rst_ni     (rst_ni),
  .cap_en_i   (cap_en_i),
  .mode_i     (mode),
  .cnt_i      (cnt),
  .held_i     (held),
  .rd_data_i  (rd_data_o),
  .rd_valid_i (rd_valid_o),
  .rd_ack_i   (rd_ack_i),
  .ovr_i      (ovr_o),
  .ovr_clr_i  (ovr_clr_i)
);

// File: tb/dsr_readout_bench.sv
`timescale 1ns/1ps
module dsr_readout_bench;
  logic        cap_clk = 1'b0;
  logic        host_clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cap_en = 1'b0;
  logic        quad = 1'b0;
  logic [3:0]  ser = '0;
  logic [31:0] rd_data;
  logic        rd_valid;
  logic        rd_ack = 1'b0;
  logic        ovr;
  logic        ovr_clr = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #1 cap_clk = ~cap_clk;   // 500 MHz capture
  always #4 host_clk = ~host_clk; // 125 MHz host

  dsr_readout u_dsr_readout (
    .cap_clk_i  (cap_clk),
    .host_clk_i (host_clk),
    .rst_ni     (rst_n),
    .cap_en_i   (cap_en),
    .quad_i     (quad),
    .ser_i      (ser),
    .rd_data_o  (rd_data),
    .rd_valid_o (rd_valid),
    .rd_ack_i   (rd_ack),
    .ovr_o      (ovr),
    .ovr_clr_i  (ovr_clr)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic host_wait(input int n);
    for (int i = 0; i < n; i++) @(negedge host_clk);
  endtask

  task automatic send_single(input logic [31:0] w, input int nbits);
    for (int i = 31; i > 31 - nbits; i--) begin
      @(negedge cap_clk);
      cap_en = 1'b1;
      ser[0] = w[i];
    end
  endtask

  task automatic send_quad(input logic [31:0] w);
    for (int i = 7; i >= 0; i--) begin
      @(negedge cap_clk);
      cap_en = 1'b1;
      for (int k = 0; k < 4; k++) ser[k] = w[8*k+i];
    end
  endtask

  task automatic stop_cap;
    @(negedge cap_clk);
    cap_en = 1'b0;
    ser = '0;
    @(negedge cap_clk);
  endtask

  task automatic set_mode(input logic q);
    @(negedge cap_clk);
    quad = q;
    repeat (2) @(negedge cap_clk);
  endtask

  task automatic read_word(input logic [31:0] exp, input string req);
    int n = 0;
    @(negedge host_clk);
    while (!rd_valid && n < 40) begin
      @(negedge host_clk);
      n++;
    end
    check(rd_valid == 1'b1, "R4 valid", {31'b0, rd_valid}, 32'd1);
    check(rd_data == exp, req, rd_data, exp);
    host_wait(3);
    check(rd_valid && rd_data == exp, "R5 hold", rd_data, exp);
    rd_ack = 1'b1;
    @(negedge host_clk);
    rd_ack = 1'b0;
    check(rd_valid == 1'b0, "R6 ack drop", {31'b0, rd_valid}, 32'd0);
    host_wait(2);
  endtask

  task automatic t_reset;
    check(rd_valid == 1'b0, "R1 valid", {31'b0, rd_valid}, 32'd0);
    check(ovr == 1'b0, "R1 ovr", {31'b0, ovr}, 32'd0);
    check(rd_data == 32'h0, "R1 data", rd_data, 32'h0);
  endtask

  task automatic t_single;
    set_mode(1'b0);
    send_single(32'hA5C3_0F12, 32);
    stop_cap();
    read_word(32'hA5C3_0F12, "R2 single word");
    send_single(32'h8000_0001, 32);
    stop_cap();
    read_word(32'h8000_0001, "R2 msb first");
  endtask

  task automatic t_quad;
    set_mode(1'b1);
    send_quad(32'h3C_81_7E_D4);
    stop_cap();
    read_word(32'h3C_81_7E_D4, "R3 quad lanes");
    send_quad(32'h01_80_FF_00);
    send_quad(32'h55_AA_0F_F0);
    stop_cap();
    read_word(32'h01_80_FF_00, "R3 quad 8 shifts");
    host_wait(6);
    check(ovr == 1'b1, "R7 quad overrun", {31'b0, ovr}, 32'd1);
    @(negedge host_clk); ovr_clr = 1'b1;
    @(negedge host_clk); ovr_clr = 1'b0;
    set_mode(1'b0);
  endtask

  task automatic t_partial;
    send_single(32'hFFFF_FFFF, 10);
    stop_cap();
    host_wait(8);
    check(rd_valid == 1'b0, "R9 partial not offered", {31'b0, rd_valid}, 32'd0);
    send_single(32'h1234_5678, 32);
    stop_cap();
    read_word(32'h1234_5678, "R9 partial discarded");
  endtask

  task automatic t_mode_frozen;
    send_single(32'hDEAD_BEEF, 12);
    quad = 1'b1;
    for (int i = 19; i >= 0; i--) begin
      @(negedge cap_clk);
      ser[0] = 1'(32'hDEAD_BEEF >> i);
    end
    @(negedge cap_clk);
    cap_en = 1'b0;
    quad = 1'b0;
    ser = '0;
    repeat (2) @(negedge cap_clk);
    read_word(32'hDEAD_BEEF, "R10 mode ignored mid word");
  endtask

  task automatic t_overrun;
    send_single(32'h0F0F_0001, 32);
    send_single(32'hF0F0_0002, 32);
    stop_cap();
    host_wait(10);
    read_word(32'h0F0F_0001, "R7 first word kept");
    host_wait(4);
    check(ovr == 1'b1, "R7 ovr set", {31'b0, ovr}, 32'd1);
    host_wait(10);
    check(rd_valid == 1'b0, "R7 second word dropped", {31'b0, rd_valid}, 32'd0);
    check(ovr == 1'b1, "R7 ovr sticky", {31'b0, ovr}, 32'd1);
    ovr_clr = 1'b1;
    @(negedge host_clk);
    ovr_clr = 1'b0;
    check(ovr == 1'b0, "R8 ovr cleared", {31'b0, ovr}, 32'd0);
    send_single(32'hC001_D00D, 32);
    stop_cap();
    read_word(32'hC001_D00D, "R6 delivery after ack");
    check(ovr == 1'b0, "R8 stays clear", {31'b0, ovr}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge host_clk);
    rst_n = 1'b1;
    host_wait(2);
    t_reset();
    t_single();
    t_quad();
    t_partial();
    t_mode_frozen();
    t_overrun();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule